// File: doc/BRIEF.md
# Multiplexed Pixel Port Serializer

This block sits between a slow, wide pixel source and a fast one-pixel-per-clock video pipeline. A load strobe it generates itself marks the pixel-clock cycles in which up to four lanes of pixel data are taken in. Each lane holds an 8-bit colour index and a 2-bit palette select. The sync and blank flags are taken in with each load. The lanes are then replayed one per pixel clock, lane A first, at a fixed latency that depends on the programmed multiplex ratio. The downstream timing relies on that latency.

The multiplex ratio is 1:1, 2:1 or 4:1. The load strobe pulses once every 1, 2 or 4 pixel clocks to match. An extended-latency option lengthens the pipeline for systems whose load alignment cannot be guaranteed. Ratio and option are sampled only in load cycles, so a change never splits a load.

Top module: `pix_mux_serializer`

## Requirements
- R1: Lanes captured in a load appear on the output one per pixel clock in the order A, B, C, D. The number of pixels emitted per load is 1, 2 or 4.
- R2: `loadOut` is high in the first cycle after reset. After a load cycle with ratio N it is low for N-1 cycles and then high again. Ratio encoding: `modeSel` 2'b00 is 1:1, 2'b01 is 2:1, and 2'b10 or 2'b11 is 4:1.
- R3: `modeSel` and `extLatency` are sampled only in cycles where `loadOut` is high. Their values in other cycles have no effect on the strobe or on the data.
- R4: In 1:1 mode, lane A of a load captured in cycle c appears in cycle c+5, whatever the value of `extLatency`.
- R5: In 2:1 mode, lane k of a load captured in cycle c appears in cycle c+6+k, or c+8+k when `extLatency` is 1.
- R6: In 4:1 mode, lane k of a load captured in cycle c appears in cycle c+8+k, or c+12+k when `extLatency` is 1.
- R7: Sync and blank are captured with each load. They travel with every pixel of that load and take the same delay as the pixel data.
- R8: After reset, all pixel outputs are zero until the first captured data reaches the output.
- R9: Lanes beyond the active ratio are ignored: B, C and D in 1:1 mode, and C and D in 2:1 mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Multiplex ratio, sampled in load cycles |
| extLatency | input | 1 | Selects the extended pipeline latency, sampled in load cycles |
| laneIdx | input | 32 | Colour index per lane, lane A in bits 7:0 up to lane D in bits 31:24 |
| lanePs | input | 8 | Palette select per lane, lane A in bits 1:0 up to lane D in bits 7:6 |
| syncIn | input | 1 | Sync flag, captured with the load |
| blankIn | input | 1 | Blank flag, captured with the load |
| loadOut | output | 1 | Load strobe; the lanes are captured at the clock edge ending a cycle in which it is high |
| pixIdx | output | 8 | Serialized colour index |
| pixPs | output | 2 | Serialized palette select |
| pixSync | output | 1 | Sync flag of the current pixel |
| pixBlank | output | 1 | Blank flag of the current pixel |

## Verification
The bench drives junk on the mode inputs in every cycle between loads. A design that sampled them early would visibly shorten or stretch the strobe period. Each ratio is run with and without extended latency, including the 1:1 case where the option must change nothing. An off-by-one tap or a missing extension shows up as every pixel landing one or more cycles early or late. The unused lanes and the sync and blank flags are randomized on every load. A design that emitted lanes in the wrong order, leaked a stale lane, or let the flags change within a load would put a wrong value on the output.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
  localparam int IDX_W     = 8;
  localparam int PS_W      = 2;
  localparam int NUM_LANES = 4;
  localparam int LAT_1TO1  = 5;
  localparam int LAT_2TO1  = 6;
  localparam int LAT_4TO1  = 8;
  localparam int EXT_2TO1  = 2;
  localparam int EXT_4TO1  = 4;
  localparam int MAX_LAT   = LAT_4TO1 + EXT_4TO1;
  // head register supplies one cycle, delay taps supply the rest
  localparam int TAP_DEPTH = MAX_LAT - 1;
  localparam int TAP_W     = $clog2(TAP_DEPTH);
  localparam int PHASE_W   = $clog2(NUM_LANES);

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [PS_W-1:0]  ps;
    logic             sync;
    logic             blank;
  } pixWord_t;

  typedef struct packed {
    logic             load;
    logic [TAP_W-1:0] tap;
  } serCtrl_t;

  function automatic int ratioOf(logic [1:0] mode);
    case (mode)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return 4;
    endcase
  endfunction

  function automatic int latencyOf(logic [1:0] mode, logic ext);
    case (mode)
      2'b00:   return LAT_1TO1;
      2'b01:   return ext ? LAT_2TO1 + EXT_2TO1 : LAT_2TO1;
      default: return ext ? LAT_4TO1 + EXT_4TO1 : LAT_4TO1;
    endcase
  endfunction
endpackage

// File: rtl/pixser_ctrl.sv
module pixser_ctrl
  import pixser_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       extLatency,
  output serCtrl_t   ctrl,
  output logic       loadOut
);
  logic [PHASE_W-1:0] phase;
  logic [TAP_W-1:0]   tapReg;
  logic               loadNow;

  assign loadNow   = (phase == '0);
  assign loadOut   = loadNow;
  assign ctrl.load = loadNow;
  assign ctrl.tap  = tapReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= '0;
      tapReg <= TAP_W'(LAT_1TO1 - 2);
    end else if (loadNow) begin
      phase  <= PHASE_W'(ratioOf(modeSel) - 1);
      tapReg <= TAP_W'(latencyOf(modeSel, extLatency) - 2);
    end else begin
      phase  <= phase - 1'b1;
    end
  end

  assert_period_1to1_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadNow && modeSel == 2'b00 |=> loadNow);
  assert_period_2to1_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadNow && modeSel == 2'b01 |=> !loadNow ##1 loadNow);
  assert_period_4to1_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadNow && modeSel[1] |=> !loadNow ##1 !loadNow ##1 !loadNow ##1 loadNow);
  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !loadNow |=> $stable(tapReg));
endmodule

// File: rtl/pixser_datapath.sv
module pixser_datapath
  import pixser_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  serCtrl_t                   ctrl,
  input  logic [NUM_LANES*IDX_W-1:0] laneIdx,
  input  logic [NUM_LANES*PS_W-1:0]  lanePs,
  input  logic                       syncIn,
  input  logic                       blankIn,
  output pixWord_t                   outWord
);
  pixWord_t laneWord  [NUM_LANES];
  pixWord_t shiftReg  [NUM_LANES];
  pixWord_t delayLine [TAP_DEPTH];

  genvar g;
  generate
    for (g = 0; g < NUM_LANES; g++) begin : gLane
      assign laneWord[g].idx   = laneIdx[g*IDX_W +: IDX_W];
      assign laneWord[g].ps    = lanePs[g*PS_W +: PS_W];
      assign laneWord[g].sync  = syncIn;
      assign laneWord[g].blank = blankIn;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LANES; i++) shiftReg[i] <= '0;
    end else if (ctrl.load) begin
      for (int i = 0; i < NUM_LANES; i++) shiftReg[i] <= laneWord[i];
    end else begin
      for (int i = 0; i < NUM_LANES - 1; i++) shiftReg[i] <= shiftReg[i+1];
      shiftReg[NUM_LANES-1] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TAP_DEPTH; i++) delayLine[i] <= '0;
    end else begin
      delayLine[0] <= shiftReg[0];
      for (int i = 1; i < TAP_DEPTH; i++) delayLine[i] <= delayLine[i-1];
    end
  end

  assign outWord = delayLine[ctrl.tap];

  assert_capture_lane_a_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> shiftReg[0] == $past(laneWord[0]));
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(shiftReg[0].sync) && $stable(shiftReg[0].blank));
endmodule

// File: rtl/pix_mux_serializer.sv
module pix_mux_serializer
  import pixser_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 modeSel,
  input  logic                       extLatency,
  input  logic [NUM_LANES*IDX_W-1:0] laneIdx,
  input  logic [NUM_LANES*PS_W-1:0]  lanePs,
  input  logic                       syncIn,
  input  logic                       blankIn,
  output logic                       loadOut,
  output logic [IDX_W-1:0]           pixIdx,
  output logic [PS_W-1:0]            pixPs,
  output logic                       pixSync,
  output logic                       pixBlank
);
  serCtrl_t ctrl;
  pixWord_t outWord;

  pixser_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .extLatency(extLatency),
    .ctrl(ctrl), .loadOut(loadOut)
  );

  pixser_datapath uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .laneIdx(laneIdx), .lanePs(lanePs),
    .syncIn(syncIn), .blankIn(blankIn), .outWord(outWord)
  );

  assign pixIdx   = outWord.idx;
  assign pixPs    = outWord.ps;
  assign pixSync  = outWord.sync;
  assign pixBlank = outWord.blank;
endmodule

// File: tb/pix_mux_serializer_test.sv
module pix_mux_serializer_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  modeSel;
  logic        extLatency;
  logic [31:0] laneIdx;
  logic [7:0]  lanePs;
  logic        syncIn, blankIn;
  logic        loadOut;
  logic [7:0]  pixIdx;
  logic [1:0]  pixPs;
  logic        pixSync, pixBlank;

  always #10 clk = ~clk;

  pix_mux_serializer uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .extLatency(extLatency),
    .laneIdx(laneIdx), .lanePs(lanePs), .syncIn(syncIn), .blankIn(blankIn),
    .loadOut(loadOut), .pixIdx(pixIdx), .pixPs(pixPs),
    .pixSync(pixSync), .pixBlank(pixBlank)
  );

  typedef struct {
    logic [7:0] idx;
    logic [1:0] ps;
    logic       s;
    logic       b;
    string      tag;
  } expWord_t;

  expWord_t expArr [int];
  int checks = 0, fails = 0, cyc = 0, nextLoad = 0, curLat = 5;
  bit done = 0;

  function automatic int refRatio(logic [1:0] m);
    return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
  endfunction

  function automatic int refLat(logic [1:0] m, logic e);
    if (m == 2'b00) return 5;
    if (m == 2'b01) return e ? 8 : 6;
    return e ? 12 : 8;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(logic [1:0] m, logic e);
    bit isLoad;
    int lat, n;
    expWord_t w;
    isLoad = (cyc == nextLoad);
    chk(loadOut === isLoad, "R2 R3", "loadOut", 32'(loadOut), 32'(isLoad));
    if (expArr.exists(cyc)) begin
      w = expArr[cyc];
      chk(pixIdx === w.idx, w.tag, "pixIdx", 32'(pixIdx), 32'(w.idx));
      chk(pixPs === w.ps, w.tag, "pixPs", 32'(pixPs), 32'(w.ps));
      chk({pixSync, pixBlank} === {w.s, w.b}, "R7", "sync/blank",
          32'({pixSync, pixBlank}), 32'({w.s, w.b}));
      expArr.delete(cyc);
    end else if (cyc < 5) begin
      chk({pixIdx, pixPs, pixSync, pixBlank} === 12'd0, "R8", "reset outputs",
          32'({pixIdx, pixPs, pixSync, pixBlank}), 32'd0);
    end
    laneIdx = $urandom;
    lanePs  = 8'($urandom);
    syncIn  = 1'($urandom);
    blankIn = 1'($urandom);
    if (isLoad) begin
      modeSel = m;
      extLatency = e;
      lat = refLat(m, e);
      n = refRatio(m);
      if (lat != curLat)
        for (int t = cyc + 1; t < cyc + lat; t++) if (expArr.exists(t)) expArr.delete(t);
      curLat = lat;
      for (int k = 0; k < n; k++) begin
        w.idx = laneIdx[k*8 +: 8];
        w.ps  = lanePs[k*2 +: 2];
        w.s   = syncIn;
        w.b   = blankIn;
        w.tag = (m == 2'b00) ? "R1 R4 R9" : (m == 2'b01) ? "R1 R5 R9" : "R1 R6";
        expArr[cyc + lat + k] = w;
      end
      nextLoad = cyc + n;
    end else begin
      modeSel = 2'($urandom);
      extLatency = 1'($urandom);
    end
    @(negedge clk);
    cyc++;
  endtask

  initial begin
    logic [1:0] cfgMode [8] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd1};
    logic       cfgExt  [8] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    rstN = 1'b0; modeSel = 2'd0; extLatency = 1'b0;
    laneIdx = '0; lanePs = '0; syncIn = 1'b0; blankIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 60; i++) step(cfgMode[s], cfgExt[s]);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule